// File: doc/BRIEF.md
# Three-Stage CIC Interpolator with Programmable Gain Removal

This block raises the sample rate of a narrow-band stream by an integer factor N using a three-stage cascaded integrator-comb structure. It takes one input sample every N clocks and delivers one output sample every clock. The combs run at the low rate and feed a hold register. The three integrators run at the full clock rate, so the overall DC gain is N cubed.

A scale-and-round stage divides the N-cubed growth back out with a right shift of 3 + SCALE + 12·BIG_SHIFT bits. It rounds half-up and clamps the result to the output width. A manual flush clears every piece of filter state. An optional automatic flush watches for a scaled value that has left the output range, treats that as an unstable filter, clears the filter by itself, and records the event in a sticky flag.

The input is a valid/ready stream, but the filter cannot wait. `in_ready` is high for exactly one cycle out of every N, and that cycle is a fixed slot. If `in_valid` is low in that slot, the filter takes a zero sample; there is no stall. The output has no ready signal. A consumer must take `out_data` in every cycle that `out_valid` is high.

Top module: `cic_interp`

## Requirements
- R1: While reset is asserted, `in_ready`, `out_valid`, `out_data` and `unstable` are all 0.
- R2: Outside flush, `in_ready` is high for exactly one cycle in every N cycles. The sample is taken when `in_valid` and `in_ready` are both high.
- R3: For a constant input x applied after a flush, the output settles within 6·N+20 cycles to round(x·N³·2^-(3+SCALE+12·BIG_SHIFT)), where SCALE is 0..15.
- R4: BIG_SHIFT adds a coarse shift in steps of 12 bits. The values 0, 1 and 2 select 0, 12 and 24 bits; the code 3 acts as 2.
- R5: Rounding is half-up: a value exactly halfway between two integers goes to the larger one. So +3.5 gives 4 and -3.5 gives -3.
- R6: The rounded result saturates to the signed range of the output width, -2^(OW-1) to 2^(OW-1)-1, and never wraps.
- R7: At each clock edge where `flush` is high, all integrator, comb, hold and output state is cleared. In the cycle that follows, `out_data` is 0, `out_valid` is 0 and `unstable` is 0. While `flush` is high, `in_ready` stays 0.
- R8: With `auto_flush_en` high, an output whose value before rounding lies outside the output range causes a self-flush on the next edge. That edge clears the filter and sets `unstable`. `out_valid` is then low for that one cycle, and `unstable` stays set until a manual flush or reset.
- R9: With `auto_flush_en` low, an out-of-range result only saturates. `out_valid` never drops and `unstable` stays 0.
- R10: A slot in which `in_valid` is low enters a zero sample. After input stops, the output returns to 0.
- R11: Outside flush, `out_valid` is high on every cycle, giving one output sample per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; output sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input slot open (one cycle per N) |
| in_data | input | IW (16) | Signed input sample |
| n_cfg | input | NW (15) | Interpolation factor N |
| scale_cfg | input | 4 | Fine shift SCALE, 0..15 |
| bshift_cfg | input | 2 | Coarse shift BIG_SHIFT, 0..2 |
| flush | input | 1 | Manual filter clear |
| auto_flush_en | input | 1 | Enable self-flush on overflow |
| out_valid | output | 1 | Output sample present |
| out_data | output | OW (16) | Signed rounded output sample |
| unstable | output | 1 | Sticky flag: a self-flush took place |

## Verification
An integrator holding a wrong value does not fade away, because integrators have no leak. A corrupted word shows up as a persistent offset or as a ramp on `out_data` within about 5 clocks, which is the hold, integrator and output register depth. A wrong comb delay or hold value produces a step error that grows through the integrators in the following samples. For that reason the steady-state values are checked at exact expected numbers after the settling window, and the decay to zero after input stops is checked as well. A slot counter that counts wrongly shows at once as the wrong spacing of `in_ready` pulses. A fault in the rounding or shift logic gives an error of one or more LSBs at the first settled sample.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int unsigned CIC_STAGES    = 3;
  localparam int unsigned FIXED_SHIFT   = 3;
  localparam int unsigned COARSE_STEP   = 12;
  localparam int unsigned HEADROOM_BASE = 18;
  localparam int unsigned MAX_BSHIFT    = 2;
  localparam int unsigned SCALE_W       = 4;
  localparam int unsigned BSHIFT_W      = 2;
  localparam int unsigned SHIFT_W       = 6;

  // total right shift = fixed + fine + 12 * coarse (coarse clamped to its max)
  function automatic logic [SHIFT_W-1:0] total_shift(input logic [SCALE_W-1:0] fine,
                                                     input logic [BSHIFT_W-1:0] coarse);
    logic [BSHIFT_W-1:0] c;
    c = (coarse > BSHIFT_W'(MAX_BSHIFT)) ? BSHIFT_W'(MAX_BSHIFT) : coarse;
    return SHIFT_W'(FIXED_SHIFT) + SHIFT_W'(fine) + SHIFT_W'(c) * SHIFT_W'(COARSE_STEP);
  endfunction
endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl #(
  parameter int NW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NW-1:0] n_cfg,
  output logic          slot_o
);
  logic [NW-1:0] phase_q;
  logic          live_q;
  logic          wrap;

  assign wrap   = ({1'b0, phase_q} + (NW+1)'(1)) >= {1'b0, n_cfg};
  assign slot_o = live_q & ~clr & (phase_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      live_q  <= 1'b0;
    end else if (clr) begin
      phase_q <= '0;
      live_q  <= 1'b1;
    end else begin
      live_q  <= 1'b1;
      phase_q <= wrap ? '0 : phase_q + NW'(1);
    end
  end

  // R2: a slot is never followed directly by another when N > 1
  a_r2_slot_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_o && n_cfg > NW'(1)) |=> !slot_o);
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int IW     = 16,
  parameter int AW     = 58,
  parameter int STAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 take,
  input  logic signed [IW-1:0] din,
  output logic signed [AW-1:0] hold_o
);
  logic signed [AW-1:0] din_ext;
  assign din_ext = {{(AW-IW){din[IW-1]}}, din};

  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    logic signed [AW-1:0] src;
    logic signed [AW-1:0] dly_q;
    logic signed [AW-1:0] diff;
    if (k == 0) begin : g_first
      assign src = din_ext;
    end else begin : g_next
      assign src = g_comb[k-1].diff;
    end
    assign diff = src - dly_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) dly_q <= '0;
      else if (take)     dly_q <= src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) hold_o <= '0;
    else if (take)     hold_o <= g_comb[STAGES-1].diff;
  end

  // R7: a clear leaves the hold register at zero
  a_r7_comb_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hold_o == '0));
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int AW     = 58,
  parameter int STAGES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [AW-1:0] din,
  output logic signed [AW-1:0] sum_o
);
  for (genvar k = 0; k < STAGES; k++) begin : g_int
    logic signed [AW-1:0] src;
    logic signed [AW-1:0] acc_q;
    if (k == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = g_int[k-1].acc_q;
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clr) acc_q <= '0;
      else               acc_q <= acc_q + src;
    end
  end

  assign sum_o = g_int[STAGES-1].acc_q;

  // R7: a clear leaves the last integrator at zero
  a_r7_integ_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_o == '0));
endmodule

// File: rtl/cic_scale_round.sv
module cic_scale_round
  import cic_pkg::*;
#(
  parameter int AW = 58,
  parameter int OW = 16
) (
  input  logic signed [AW-1:0]       acc_i,
  input  logic        [SCALE_W-1:0]  scale_i,
  input  logic        [BSHIFT_W-1:0] bshift_i,
  output logic signed [OW-1:0]       out_o,
  output logic                       ovf_o
);
  localparam logic signed [AW:0] OMAX = (AW+1)'((64'sd1 <<< (OW-1)) - 64'sd1);
  localparam logic signed [AW:0] OMIN = ~OMAX;

  logic        [SHIFT_W-1:0] sh;
  logic        [AW:0]        unit;
  logic signed [AW:0]        half;
  logic signed [AW:0]        acc_x;
  logic signed [AW:0]        biased;
  logic signed [AW:0]        rnd;
  logic signed [AW:0]        trunc;

  always_comb begin
    sh     = total_shift(scale_i, bshift_i);
    unit   = {{AW{1'b0}}, 1'b1} << sh;
    half   = $signed({1'b0, unit[AW:1]});
    acc_x  = {acc_i[AW-1], acc_i};
    biased = acc_x + half;
    rnd    = biased >>> sh;
    trunc  = acc_x >>> sh;
    ovf_o  = (trunc > OMAX) || (trunc < OMIN);
    if (rnd > OMAX)      out_o = OMAX[OW-1:0];
    else if (rnd < OMIN) out_o = OMIN[OW-1:0];
    else                 out_o = rnd[OW-1:0];
  end
endmodule

// File: rtl/cic_interp.sv
module cic_interp
  import cic_pkg::*;
#(
  parameter int IW = 16,
  parameter int OW = 16,
  parameter int NW = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [IW-1:0]       in_data,
  input  logic        [NW-1:0]       n_cfg,
  input  logic        [SCALE_W-1:0]  scale_cfg,
  input  logic        [BSHIFT_W-1:0] bshift_cfg,
  input  logic                       flush,
  input  logic                       auto_flush_en,
  output logic                       out_valid,
  output logic signed [OW-1:0]       out_data,
  output logic                       unstable
);
  localparam int AW = IW + HEADROOM_BASE + COARSE_STEP * MAX_BSHIFT;

  logic                 ovf_q;
  logic                 flush_all;
  logic                 slot;
  logic signed [IW-1:0] din_gated;
  logic signed [AW-1:0] hold;
  logic signed [AW-1:0] integ_out;
  logic signed [OW-1:0] scaled;
  logic                 ovf;

  assign flush_all = flush | (auto_flush_en & ovf_q);
  assign in_ready  = slot;
  assign din_gated = in_valid ? in_data : '0;

  cic_rate_ctrl #(.NW(NW)) u_rate (
    .clk(clk), .rst_n(rst_n), .clr(flush_all), .n_cfg(n_cfg), .slot_o(slot)
  );

  cic_comb_chain #(.IW(IW), .AW(AW), .STAGES(CIC_STAGES)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(flush_all), .take(slot),
    .din(din_gated), .hold_o(hold)
  );

  cic_integ_chain #(.AW(AW), .STAGES(CIC_STAGES)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(flush_all), .din(hold), .sum_o(integ_out)
  );

  cic_scale_round #(.AW(AW), .OW(OW)) u_scale (
    .acc_i(integ_out), .scale_i(scale_cfg), .bshift_i(bshift_cfg),
    .out_o(scaled), .ovf_o(ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      ovf_q     <= 1'b0;
      unstable  <= 1'b0;
    end else if (flush_all) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      ovf_q     <= 1'b0;
      unstable  <= ~flush;
    end else begin
      out_data  <= scaled;
      out_valid <= 1'b1;
      ovf_q     <= ovf;
    end
  end

  // R7: manual flush empties the output and clears the flag
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_data == '0 && !out_valid && !unstable));

  // R8: a detected overflow with auto flush on drops one sample and raises the flag
  a_r8_self_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_flush_en && ovf_q && !flush) |=> (!out_valid && unstable));

  // R8: the flag holds until a manual flush
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unstable && !flush) |=> unstable);

  // R9/R11: without auto flush the stream never breaks outside a manual flush
  a_r11_stream_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !auto_flush_en && !flush) |=> out_valid);
endmodule

// File: tb/cic_interp_bench.sv
`timescale 1ns/1ps
module cic_interp_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               feed_en = 1'b0;
  logic signed [15:0] cur_x = '0;
  logic               in_ready;
  logic [14:0]        n_cfg = 15'd8;
  logic [3:0]         scale_cfg = '0;
  logic [1:0]         bshift_cfg = '0;
  logic               flush = 1'b0;
  logic               auto_en = 1'b0;
  logic               out_valid;
  logic signed [15:0] out_data;
  logic               unstable;

  int  vectors = 0;
  int  miscomp = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  cic_interp u_cic_interp (
    .clk(clk), .rst_n(rst_n), .in_valid(feed_en), .in_ready(in_ready),
    .in_data(cur_x), .n_cfg(n_cfg), .scale_cfg(scale_cfg), .bshift_cfg(bshift_cfg),
    .flush(flush), .auto_flush_en(auto_en), .out_valid(out_valid),
    .out_data(out_data), .unstable(unstable)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic longint expect_out(input longint x, input longint n,
                                        input int s, input int b);
    int     bb;
    int     sh;
    longint r;
    bb = (b > 2) ? 2 : b;
    sh = 3 + s + 12 * bb;
    r  = (x * n * n * n + (64'sd1 <<< (sh - 1))) >>> sh;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic restart(input int n, input int s, input int b, input int x,
                         input bit feed, input bit aut);
    @(negedge clk);
    flush = 1'b1; n_cfg = 15'(n); scale_cfg = 4'(s); bshift_cfg = 2'(b);
    cur_x = 16'(x); feed_en = feed; auto_en = aut;
    wait_n(2);
    flush = 1'b0;
  endtask

  task automatic t_reset;
    wait_n(2);
    chk("R1 in_ready in reset", in_ready, 0);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 out_data in reset", out_data, 0);
    chk("R1 unstable in reset", unstable, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_dc(input int n, input int s, input int b, input int x, input string tag);
    restart(n, s, b, x, 1'b1, 1'b0);
    wait_n(6 * n + 20);
    chk(tag, $signed(out_data), expect_out(x, n, s, b));
    wait_n(1);
    chk({tag, " held"}, $signed(out_data), expect_out(x, n, s, b));
  endtask

  task automatic t_slots(input int n, input int span);
    int cnt;
    restart(n, 0, 0, 0, 1'b1, 1'b0);
    cnt = 0;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (in_ready) cnt++;
    end
    chk("R2 in_ready pulse count", cnt, span / n);
  endtask

  task automatic t_underrun;
    t_dc(8, 6, 0, 1000, "R3 unity gain before underrun");
    feed_en = 1'b0;
    wait_n(6 * 8 + 20);
    chk("R10 output decays with no input", $signed(out_data), 0);
  endtask

  task automatic t_saturate;
    int drops;
    restart(8, 0, 0, 10000, 1'b1, 1'b0);
    wait_n(2);
    drops = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!out_valid) drops++;
    end
    chk("R6 positive saturation", $signed(out_data), 32767);
    chk("R9 no flag without auto flush", unstable, 0);
    chk("R11 out_valid every cycle", drops, 0);
    t_dc(8, 0, 0, -10000, "R6 negative saturation");
  endtask

  task automatic t_auto;
    int drops;
    restart(8, 0, 0, 10000, 1'b1, 1'b1);
    drops = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!out_valid) drops++;
    end
    chk("R8 flag set by self flush", unstable, 1);
    chk("R8 self flush dropped samples", (drops > 0) ? 1 : 0, 1);
    @(negedge clk);
    flush = 1'b1;
    wait_n(1);
    chk("R7 flag cleared by flush", unstable, 0);
    chk("R7 out_valid low in flush", out_valid, 0);
    chk("R7 out_data zero in flush", out_data, 0);
    chk("R7 in_ready low in flush", in_ready, 0);
    flush = 1'b0;
    auto_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_slots(8, 40);
    t_slots(13, 39);
    t_dc(8, 6, 0, 1000, "R3 unity gain N=8");
    t_dc(10, 4, 0, 3, "R3 N=10 positive");
    t_dc(10, 4, 0, -5, "R3 N=10 negative");
    t_dc(8, 7, 0, 7, "R5 half rounds up positive");
    t_dc(8, 7, 0, -7, "R5 half rounds up negative");
    t_dc(65, 0, 1, 100, "R4 coarse shift 12");
    t_dc(1025, 0, 2, 1000, "R4 coarse shift 24");
    t_dc(1025, 0, 3, 1000, "R4 code 3 acts as 2");
    t_underrun();
    t_saturate();
    t_auto();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      vectors++;
      miscomp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end
endmodule